// File: doc/BRIEF.md
# Startup and Manual Reset Supervisor

This block controls the reset line of a host processor from power-on onward. After power-on it waits a set number of slow oscillator ticks. It then asks an external measurement circuit to read the interval setting from a shared pin, and it keeps the host in reset until that read reports completion. From then on, the same pin is a manual-reset input. If the pin is seen high on enough consecutive ticks, the supervisor clears the watchdog timer and drives the reset low. It keeps both that way for as long as the pin stays high, and releases them only after the pin has dropped and a full reset pulse has elapsed.

A manual reset that arrives before the interval setting has been read cancels the read. When the reset pulse ends, the read is requested again. Once one read has completed, later manual resets return straight to normal operation and the setting is never read again. All timing is counted in oscillator ticks, which arrive as single-cycle strobes on `tick`. The pin is synchronised inside the block and is looked at only on tick cycles.

Top module: `mrst_supervisor`

## Requirements
- R1: While the power-on reset `por_n` is low, `host_rst_n` is 0, `wd_clear` is 1 and `cfg_read_req` is 0.
- R2: After power-on, `cfg_read_req` pulses high for exactly one clock cycle, in the cycle after the POR_TICKS-th tick. No request is made before that tick.
- R3: From power-on until `cfg_read_done` is accepted, `host_rst_n` stays 0 and `wd_clear` stays 1. In the cycle after an accepted `cfg_read_done`, `host_rst_n` is 1 and `wd_clear` is 0.
- R4: `cfg_read_done` has no effect unless a read is pending. This holds before the request, during normal operation and during a manual reset.
- R5: A pin that is high on fewer than DEB_TICKS consecutive ticks has no effect on `host_rst_n` or `wd_clear`.
- R6: On the DEB_TICKS-th consecutive tick that samples the pin high, `host_rst_n` goes to 0 and `wd_clear` goes to 1 in the next cycle. This applies in every phase.
- R7: While the pin stays high, the reset and the clear are held for any number of ticks.
- R8: After the first tick that samples the pin low, the reset and the clear persist through TAIL_TICKS further ticks. They release in the cycle after the last of those ticks.
- R9: A manual reset taken before the read completes cancels the read. A new single-cycle `cfg_read_req` follows the end of the reset pulse, and the host stays in reset until `cfg_read_done`. If the manual reset qualifies on the same tick that ends the power-on wait, the manual reset wins and no request is issued.
- R10: After one completed read, `cfg_read_req` never rises again until the next power-on reset. A manual reset then ends directly in normal operation.
- R11: The pin is sampled only on tick cycles. A high level that starts and ends between two ticks has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tick | input | 1 | Single-cycle oscillator tick strobe |
| mr_pin | input | 1 | Raw level of the shared manual-reset / configuration pin |
| cfg_read_done | input | 1 | Strobe from the measurement circuit: the interval read has finished |
| cfg_read_req | output | 1 | Single-cycle request to start the interval read |
| wd_clear | output | 1 | Holds the watchdog counters cleared while high |
| host_rst_n | output | 1 | Active-low reset to the host |

## Verification
The hardest case to reach is a manual reset that lands while the interval read is still pending. The case where it qualifies on the very tick that ends the power-on wait is harder still. The bench reaches these by applying power-on reset again, stepping an exact number of ticks, and raising the pin so that its second high sample falls on the chosen tick. It then counts the read requests seen after the reset tail. A sweep of pin-high lengths in normal operation covers the debounce threshold and the tail length.

// File: rtl/mrst_sup_pkg.sv
package mrst_sup_pkg;

  typedef enum logic [2:0] {
    SUP_POWERUP  = 3'd0,
    SUP_CFGREAD  = 3'd1,
    SUP_ACTIVE   = 3'd2,
    SUP_MR_HOLD  = 3'd3,
    SUP_MR_TAIL  = 3'd4
  } sup_state_t;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned top_value);
    return (top_value < 2) ? 1 : $clog2(top_value + 1);
  endfunction

  // Host is released only in normal operation.
  function automatic logic releases_host(input sup_state_t s);
    return (s == SUP_ACTIVE);
  endfunction

endpackage

// File: rtl/mrst_sync.sv
module mrst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= d_in;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/mrst_debounce.sv
module mrst_debounce #(
  parameter int unsigned DEB_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin_s,
  output logic qualify
);
  localparam int unsigned CW = mrst_sup_pkg::cnt_width(DEB_TICKS);
  localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (tick) begin
      if (!pin_s) run_q <= '0;
      else if (run_q != LAST) run_q <= run_q + 1'b1;
    end
  end

  // Fires on the tick that completes the required run of high samples.
  assign qualify = tick && pin_s && (run_q == LAST);
endmodule

// File: rtl/mrst_tick_timer.sv
module mrst_tick_timer #(
  parameter int unsigned MAX_TICKS = 32
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           tick,
  input  logic                                           restart,
  input  logic [mrst_sup_pkg::cnt_width(MAX_TICKS)-1:0]  limit,
  output logic                                           expire
);
  localparam int unsigned CW = mrst_sup_pkg::cnt_width(MAX_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

  assign expire = tick && (cnt_q == limit - 1'b1);
endmodule

// File: rtl/mrst_supervisor.sv
module mrst_supervisor #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_TICKS   = 2,
  parameter int unsigned POR_TICKS   = 4,
  parameter int unsigned TAIL_TICKS  = 32
) (
  input  logic clk,
  input  logic por_n,
  input  logic tick,
  input  logic mr_pin,
  input  logic cfg_read_done,
  output logic cfg_read_req,
  output logic wd_clear,
  output logic host_rst_n
);
  import mrst_sup_pkg::*;

  localparam int unsigned TMAX = max_u(POR_TICKS, TAIL_TICKS);
  localparam int unsigned TW   = cnt_width(TMAX);

  sup_state_t state_q, state_d;
  logic       pin_s;
  logic       mr_hit;
  logic       tmr_expire;
  logic       tmr_restart;
  logic [TW-1:0] tmr_limit;
  logic       cfg_valid_q, cfg_valid_d;
  logic       req_q, req_d;
  logic       in_hold;
  logic       hold_exit;

  mrst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(por_n), .d_in(mr_pin), .d_out(pin_s)
  );

  mrst_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
    .clk(clk), .rst_n(por_n), .tick(tick), .pin_s(pin_s), .qualify(mr_hit)
  );

  assign tmr_limit   = (state_q == SUP_POWERUP) ? TW'(POR_TICKS) : TW'(TAIL_TICKS);
  assign tmr_restart = (state_d != state_q);

  mrst_tick_timer #(.MAX_TICKS(TMAX)) u_tmr (
    .clk(clk), .rst_n(por_n), .tick(tick), .restart(tmr_restart),
    .limit(tmr_limit), .expire(tmr_expire)
  );

  assign in_hold   = (state_q == SUP_MR_HOLD);
  assign hold_exit = in_hold && tick && !pin_s;

  always_comb begin
    state_d     = state_q;
    cfg_valid_d = cfg_valid_q;
    req_d       = 1'b0;
    unique case (state_q)
      SUP_POWERUP: begin
        if (mr_hit) state_d = SUP_MR_HOLD;
        else if (tmr_expire) begin
          state_d = SUP_CFGREAD;
          req_d   = 1'b1;
        end
      end
      SUP_CFGREAD: begin
        if (mr_hit) state_d = SUP_MR_HOLD;
        else if (cfg_read_done) begin
          state_d     = SUP_ACTIVE;
          cfg_valid_d = 1'b1;
        end
      end
      SUP_ACTIVE: begin
        if (mr_hit) state_d = SUP_MR_HOLD;
      end
      SUP_MR_HOLD: begin
        if (hold_exit) state_d = SUP_MR_TAIL;
      end
      SUP_MR_TAIL: begin
        if (mr_hit) state_d = SUP_MR_HOLD;
        else if (tmr_expire) begin
          if (cfg_valid_q) state_d = SUP_ACTIVE;
          else begin
            state_d = SUP_CFGREAD;
            req_d   = 1'b1;
          end
        end
      end
      default: state_d = SUP_POWERUP;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q     <= SUP_POWERUP;
      cfg_valid_q <= 1'b0;
      req_q       <= 1'b0;
    end else begin
      state_q     <= state_d;
      cfg_valid_q <= cfg_valid_d;
      req_q       <= req_d;
    end
  end

  assign host_rst_n   = releases_host(state_q);
  assign wd_clear     = !releases_host(state_q);
  assign cfg_read_req = req_q;

endmodule

// File: rtl/mrst_sup_checker.sv
module mrst_sup_checker (
  input logic clk,
  input logic por_n,
  input logic tick,
  input logic cfg_read_done,
  input logic cfg_read_req,
  input logic wd_clear,
  input logic host_rst_n,
  input logic mr_hit,
  input logic in_hold,
  input logic hold_exit,
  input logic cfg_valid_q
);
  assert_req_single_R2: assert property (@(posedge clk) disable iff (!por_n)
    cfg_read_req |=> !cfg_read_req);

  assert_req_under_reset_R3: assert property (@(posedge clk) disable iff (!por_n)
    cfg_read_req |-> (!host_rst_n && wd_clear));

  assert_mr_forces_reset_R6: assert property (@(posedge clk) disable iff (!por_n)
    mr_hit |=> (!host_rst_n && wd_clear));

  assert_hold_persists_R7: assert property (@(posedge clk) disable iff (!por_n)
    (in_hold && !hold_exit) |=> in_hold);

  assert_release_needs_event_R8: assert property (@(posedge clk) disable iff (!por_n)
    (!host_rst_n && !tick && !cfg_read_done) |=> !host_rst_n);

  assert_read_once_R10: assert property (@(posedge clk) disable iff (!por_n)
    cfg_valid_q |-> !cfg_read_req);
endmodule

bind mrst_supervisor mrst_sup_checker u_chk (
  .clk(clk), .por_n(por_n), .tick(tick), .cfg_read_done(cfg_read_done),
  .cfg_read_req(cfg_read_req), .wd_clear(wd_clear), .host_rst_n(host_rst_n),
  .mr_hit(mr_hit), .in_hold(in_hold), .hold_exit(hold_exit),
  .cfg_valid_q(cfg_valid_q)
);

// File: tb/tb_mrst_supervisor.sv
module tb_mrst_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int DEB  = 2;
  localparam int PORT = 3;
  localparam int TAIL = 4;

  logic clk = 1'b0, por_n = 1'b0, tick = 1'b0, mr_pin = 1'b0, cfg_read_done = 1'b0;
  logic cfg_read_req, wd_clear, host_rst_n;

  int checks = 0, errors = 0, req_seen = 0, req_base = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mrst_supervisor #(.SYNC_STAGES(2), .DEB_TICKS(DEB), .POR_TICKS(PORT), .TAIL_TICKS(TAIL)) dut (
    .clk(clk), .por_n(por_n), .tick(tick), .mr_pin(mr_pin), .cfg_read_done(cfg_read_done),
    .cfg_read_req(cfg_read_req), .wd_clear(wd_clear), .host_rst_n(host_rst_n)
  );

  always @(posedge clk) if (cfg_read_req) req_seen++;

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_tick();
    tick = 1'b1; @(negedge clk); tick = 1'b0; idle(3);
  endtask

  task automatic set_pin(input logic v);
    mr_pin = v; idle(3);
  endtask

  task automatic pulse_done();
    cfg_read_done = 1'b1; @(negedge clk); cfg_read_done = 1'b0; idle(1);
  endtask

  task automatic power_on();
    por_n = 1'b0; mr_pin = 1'b0; idle(3);
    por_n = 1'b1; req_base = req_seen; idle(2);
  endtask

  task automatic chk_rst(input string req, input logic exp_rel);
    checks++;
    if (host_rst_n !== exp_rel || wd_clear !== !exp_rel) begin
      errors++;
      $display("FAIL %s host_rst_n=%b wd_clear=%b expected %b/%b", req, host_rst_n, wd_clear, exp_rel, !exp_rel);
    end
  endtask

  task automatic chk_req(input string req, input int exp_n);
    checks++;
    if (req_seen - req_base != exp_n) begin
      errors++;
      $display("FAIL %s read requests=%0d expected %0d", req, req_seen - req_base, exp_n);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(2);
    // R1: outputs while power-on reset is held
    chk_rst("R1", 1'b0);
    checks++;
    if (cfg_read_req !== 1'b0) begin errors++; $display("FAIL R1 cfg_read_req=%b expected 0", cfg_read_req); end
    por_n = 1'b1; idle(2);

    // R4: done strobe during the power-up wait is ignored
    pulse_done();
    chk_rst("R4", 1'b0);
    for (int t = 1; t <= PORT; t++) begin
      do_tick();
      chk_req("R2", (t == PORT) ? 1 : 0);
      chk_rst("R3", 1'b0);
    end
    // R3: read pending holds reset regardless of ticks
    for (int t = 0; t < 5; t++) do_tick();
    chk_rst("R3", 1'b0);
    pulse_done();
    chk_rst("R3", 1'b1);
    pulse_done();
    chk_rst("R4", 1'b1);

    // Sweep of pin-high lengths in normal operation
    for (int len = 1; len <= 5; len++) begin
      set_pin(1'b1);
      for (int k = 1; k <= len; k++) begin
        do_tick();
        chk_rst((k < DEB) ? "R5" : ((k == DEB) ? "R6" : "R7"), (k < DEB));
      end
      if (len >= DEB) begin
        pulse_done();
        chk_rst("R4", 1'b0);
      end
      set_pin(1'b0);
      do_tick();
      chk_rst("R8", len < DEB);
      for (int j = 1; j <= TAIL; j++) begin
        do_tick();
        chk_rst("R8", (len < DEB) || (j >= TAIL));
      end
    end
    chk_req("R10", 1);

    // R11: pin high only between ticks
    for (int r = 0; r < 3; r++) begin
      set_pin(1'b1); set_pin(1'b0); do_tick();
    end
    chk_rst("R11", 1'b1);

    // R9: abort during the pending read
    power_on();
    for (int t = 0; t < PORT; t++) do_tick();
    chk_req("R2", 1);
    set_pin(1'b1); do_tick(); do_tick();
    chk_rst("R9", 1'b0);
    pulse_done();
    chk_rst("R9", 1'b0);
    set_pin(1'b0); do_tick();
    for (int j = 0; j < TAIL; j++) do_tick();
    chk_req("R9", 2);
    chk_rst("R9", 1'b0);
    pulse_done();
    chk_rst("R9", 1'b1);

    // R9: qualification on the tick that ends the power-up wait wins
    power_on();
    do_tick();
    set_pin(1'b1); do_tick(); do_tick();
    chk_req("R9", 0);
    chk_rst("R9", 1'b0);
    set_pin(1'b0); do_tick();
    for (int j = 0; j < TAIL; j++) do_tick();
    chk_req("R9", 1);
    pulse_done();
    chk_rst("R9", 1'b1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule